// File: doc/BRIEF.md
# PCM Frame Serializer Encoder

The block turns one digitized sample per frame into a serial pulse-code-modulated bit stream, one bit for each bit-clock period. A frame is eight bit periods long. The signed two's-complement sample from an external converter is mapped onto an offset-binary quantizer code. Level 0 is the most negative level. The mapping rounds to the nearest level and saturates at the top level. The code is sent most significant bit first. A mode input selects a 4-bit code (16 levels) or a 7-bit code (128 levels). In 4-bit mode the three unused leading slots carry zeros.

The last slot of every frame carries a frame-alignment bit. This bit alternates between 1 and 0 on successive frames, and a downstream decoder uses it to lock onto frame boundaries. A frame-sync strobe is high for exactly that last slot. The sample and the mode are captured together at the first slot of a frame, so the sample rate is the bit clock divided by eight.

Output timing: the sample and mode are taken at the clock edge on which the internal slot counter is at its first slot. Each slot's bit is then presented on `pcm_o` for the clock period that follows the edge on which that slot is served. After reset is released, the first clock edge begins a frame.

Top module: `pcm_frame_encoder`

## Requirements
- R1: A frame lasts exactly eight clock periods, and `fs_o` is high only during the eighth (alignment) period of each frame, for one period.
- R2: The alignment bit in the eighth period alternates 1, 0, 1, ... on successive frames, and the first frame after reset carries 1.
- R3: With `mode_i` = 1 (7-bit mode), periods 1 to 7 of a frame carry the 7-bit code, most significant bit first.
- R4: With `mode_i` = 0 (4-bit mode), periods 1 to 3 carry 0 and periods 4 to 7 carry the 4-bit code, most significant bit first.
- R5: The code is the nearest quantizer level to the sample. With W sample bits and n code bits, the code is floor((sample + 2^(W-1) + 2^(W-n-1)) / 2^(W-n)), so the most negative sample gives code 0.
- R6: A result above L-1 (L = 16 or 128) saturates to L-1, which is all ones.
- R7: The sample is captured at the first slot of a frame. Changes to `sample_i` during the rest of that frame do not alter the frame.
- R8: A change of `mode_i` inside a frame does not affect that frame. The change takes effect at the next frame boundary.
- R9: While `rst_n` is low at a clock edge, `pcm_o` and `fs_o` are low and the slot counter is cleared. The first edge after release starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one slot per period |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | SAMPLE_W | Signed two's-complement sample |
| mode_i | input | 1 | Code size: 1 = 7-bit, 0 = 4-bit |
| pcm_o | output | 1 | Serial frame stream |
| fs_o | output | 1 | Frame-sync strobe on the alignment slot |

## Verification
The hardest behaviours to reach from the ports are the rounding boundaries and the frame-boundary capture. The bench drives samples that sit one count either side of a rounding midpoint in both modes, together with both ends of full scale. To show that sample and mode are captured only at the frame boundary, the bench flips both inputs one period into a frame and checks that the serialized frame still matches the values present at the first slot. A reset applied in mid-frame checks that the alignment sequence restarts at 1 however many frames came before.

// File: rtl/pcm_enc_pkg.sv
// Package: shared frame geometry and mode encoding for the PCM encoder.
// Assumes the wide code fills every slot before the alignment slot.
package pcm_enc_pkg;
    localparam int CODE_NARROW = 4;
    localparam int CODE_WIDE   = 7;
    localparam int FRAME_SLOTS = CODE_WIDE + 1;
    localparam int PAD_SLOTS   = CODE_WIDE - CODE_NARROW;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } pcm_mode_e;
endpackage

// File: rtl/pcm_slot_timer.sv
// Module: pcm_slot_timer
// Counts bit-clock periods within a frame and flags the first and last slot.
// Assumes SLOTS >= 2; synchronous active-low reset clears the count to slot 0.
module pcm_slot_timer #(
    parameter int SLOTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic first_o,
    output logic last_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;

    // Advance the slot index, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + SLOT_W'(1);
        end
    end

    assign first_o = (slot_q == '0);
    assign last_o  = (slot_q == LAST_SLOT);

    // R1: after the last slot the next period is the first slot.
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> first_o);

    // R1: otherwise the index moves up by exactly one.
    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !last_o |=> (slot_q == $past(slot_q) + SLOT_W'(1)));
endmodule

// File: rtl/pcm_quantizer.sv
// Module: pcm_quantizer
// Maps a signed sample to an offset-binary code of CODE_W bits, rounding to
// the nearest level and saturating at the top. Assumes SAMPLE_W > CODE_W.
module pcm_quantizer #(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 4
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic        [CODE_W-1:0]   code_o
);
    localparam int SHIFT = SAMPLE_W - CODE_W;
    localparam logic [SAMPLE_W:0] HALF_STEP = (SAMPLE_W + 1)'(1) << (SHIFT - 1);
    localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic signed [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [SAMPLE_W:0] biased;
    logic [SAMPLE_W:0] rounded;
    logic [CODE_W:0]   level;

    // Offset-binary conversion, rounding and saturation.
    always_comb begin
        biased  = {1'b0, ~sample_i[SAMPLE_W-1], sample_i[SAMPLE_W-2:0]};
        rounded = biased + HALF_STEP;
        level   = (CODE_W + 1)'(rounded >> SHIFT);
        code_o  = level[CODE_W] ? {CODE_W{1'b1}} : level[CODE_W-1:0];
    end

    // R5 and R6: the ends of the input range land on the ends of the code range.
    always_comb begin
        if (sample_i == MOST_NEG) begin
            p_floor_r5: assert (code_o == '0);
        end
        if (sample_i == MOST_POS) begin
            p_saturate_r6: assert (code_o == {CODE_W{1'b1}});
        end
    end
endmodule

// File: rtl/pcm_frame_shifter.sv
// Module: pcm_frame_shifter
// Builds the frame word at the first slot from the selected code, shifts it out
// MSB first, and ends the frame with the alternating alignment bit and strobe.
// Assumes first_i/last_i come from a slot timer of FRAME_SLOTS periods.
module pcm_frame_shifter
    import pcm_enc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   first_i,
    input  logic                   last_i,
    input  logic                   mode_i,
    input  logic [CODE_NARROW-1:0] code_narrow_i,
    input  logic [CODE_WIDE-1:0]   code_wide_i,
    output logic                   pcm_o,
    output logic                   fs_o
);
    logic [CODE_WIDE-1:0] word;
    logic [CODE_WIDE-1:0] shreg_q;
    logic                 align_q;
    logic                 pcm_q;
    logic                 fs_q;

    // Select the frame payload: wide code, or narrow code behind zero padding.
    always_comb begin
        if (pcm_mode_e'(mode_i) == MODE_WIDE) begin
            word = code_wide_i;
        end else begin
            word = {{PAD_SLOTS{1'b0}}, code_narrow_i};
        end
    end

    // Serialize the payload, then the alignment bit, one slot per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            align_q <= 1'b1;
            pcm_q   <= 1'b0;
            fs_q    <= 1'b0;
        end else begin
            fs_q <= last_i;
            if (first_i) begin
                pcm_q   <= word[CODE_WIDE-1];
                shreg_q <= word << 1;
            end else if (last_i) begin
                pcm_q   <= align_q;
                align_q <= ~align_q;
            end else begin
                pcm_q   <= shreg_q[CODE_WIDE-1];
                shreg_q <= shreg_q << 1;
            end
        end
    end

    assign pcm_o = pcm_q;
    assign fs_o  = fs_q;

    // R1: the strobe lasts one period.
    p_fs_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |=> !fs_o);

    // R1: strobes repeat every eight periods.
    p_fs_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> ##8 fs_o);

    // R2: consecutive alignment bits differ.
    p_align_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> ##8 (pcm_o != $past(pcm_o, 8)));

    // R3: in wide mode the first slot carries the code MSB.
    p_wide_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_i && mode_i) |=> (pcm_o == $past(code_wide_i[CODE_WIDE-1])));

    // R4: in narrow mode the three leading slots are zero.
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (first_i && !mode_i) |=> !pcm_o ##1 !pcm_o ##1 !pcm_o);
endmodule

// File: rtl/pcm_frame_encoder.sv
// Module: pcm_frame_encoder (top)
// Serial PCM encoder: quantizes a signed sample into 4- or 7-bit offset
// binary, and sends an eight-slot frame ending in an alternating alignment bit
// with a frame-sync strobe. Assumes SAMPLE_W exceeds the wide code width.
module pcm_frame_encoder
    import pcm_enc_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       mode_i,
    output logic                       pcm_o,
    output logic                       fs_o
);
    logic                   first_slot;
    logic                   last_slot;
    logic [CODE_NARROW-1:0] code_narrow;
    logic [CODE_WIDE-1:0]   code_wide;

    pcm_slot_timer #(
        .SLOTS(FRAME_SLOTS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .first_o(first_slot),
        .last_o (last_slot)
    );

    pcm_quantizer #(
        .SAMPLE_W(SAMPLE_W),
        .CODE_W  (CODE_NARROW)
    ) u_quant_narrow (
        .sample_i(sample_i),
        .code_o  (code_narrow)
    );

    pcm_quantizer #(
        .SAMPLE_W(SAMPLE_W),
        .CODE_W  (CODE_WIDE)
    ) u_quant_wide (
        .sample_i(sample_i),
        .code_o  (code_wide)
    );

    pcm_frame_shifter u_shifter (
        .clk          (clk),
        .rst_n        (rst_n),
        .first_i      (first_slot),
        .last_i       (last_slot),
        .mode_i       (mode_i),
        .code_narrow_i(code_narrow),
        .code_wide_i  (code_wide),
        .pcm_o        (pcm_o),
        .fs_o         (fs_o)
    );
endmodule

// File: tb/tb_pcm_frame_encoder.sv
// Directed bench for pcm_frame_encoder: one task per scenario.
module tb_pcm_frame_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic signed [W-1:0] sample_i = '0;
    logic                mode_i = 1'b0;
    logic                pcm_o;
    logic                fs_o;

    int checks = 0;
    int fails = 0;
    logic exp_align = 1'b1;

    pcm_frame_encoder #(.SAMPLE_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .mode_i(mode_i), .pcm_o(pcm_o), .fs_o(fs_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected code from the rounding rule of R5 with saturation of R6.
    function automatic int exp_code(input int s, input int n);
        int step = 1 << (W - n);
        int q = (s + (1 << (W - 1)) + step / 2) / step;
        if (q > (1 << n) - 1) q = (1 << n) - 1;
        return q;
    endfunction

    function automatic logic [7:0] exp_frame(input int s, input bit wide, input logic al);
        int c = exp_code(s, wide ? 7 : 4);
        return {c[6:0], al};
    endfunction

    // Hold reset, check idle outputs, release at a falling edge (R9).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pcm_o == 1'b0 && fs_o == 1'b0, "R9 outputs low in reset", {pcm_o, fs_o}, 0);
        rst_n = 1'b1;
        exp_align = 1'b1;
    endtask

    // Send one frame from the current falling edge; optionally disturb inputs (R7, R8).
    task automatic run_frame(input int s, input bit wide, input bit disturb, input string tag);
        logic [7:0] got;
        logic [7:0] fsp;
        logic [7:0] exp;
        sample_i = W'(s);
        mode_i = wide;
        exp = exp_frame(s, wide, exp_align);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            got[7-k] = pcm_o;
            fsp[7-k] = fs_o;
            if (disturb && k == 0) begin
                sample_i = ~sample_i;
                mode_i = ~mode_i;
            end
        end
        check(got == exp, tag, got, exp);
        check(fsp == 8'b0000_0001, "R1 strobe only in slot 8", fsp, 8'h01);
        exp_align = ~exp_align;
    endtask

    task automatic t_first_frames();
        do_reset();
        run_frame(0, 1'b0, 1'b0, "R4 R2 R9 narrow zero, first align 1");
        run_frame(0, 1'b1, 1'b0, "R3 R2 wide zero, align 0");
        run_frame(1000, 1'b1, 1'b0, "R3 wide mid-positive");
        run_frame(-700, 1'b0, 1'b0, "R4 narrow mid-negative");
    endtask

    task automatic t_full_scale();
        run_frame(-2048, 1'b0, 1'b0, "R5 narrow most negative");
        run_frame(-2048, 1'b1, 1'b0, "R5 wide most negative");
        run_frame(2047, 1'b0, 1'b0, "R6 narrow saturation");
        run_frame(2047, 1'b1, 1'b0, "R6 wide saturation");
    endtask

    task automatic t_rounding();
        run_frame(127, 1'b0, 1'b0, "R5 narrow below midpoint");
        run_frame(128, 1'b0, 1'b0, "R5 narrow at midpoint");
        run_frame(-129, 1'b0, 1'b0, "R5 narrow negative below midpoint");
        run_frame(15, 1'b1, 1'b0, "R5 wide below midpoint");
        run_frame(16, 1'b1, 1'b0, "R5 wide at midpoint");
    endtask

    task automatic t_capture_hold();
        run_frame(300, 1'b1, 1'b1, "R7 R8 wide frame holds under disturb");
        run_frame(300, 1'b0, 1'b1, "R7 R8 narrow frame holds under disturb");
        run_frame(-1500, 1'b1, 1'b0, "R8 new mode at boundary");
    endtask

    task automatic t_mid_reset();
        sample_i = W'(900);
        mode_i = 1'b1;
        repeat (3) @(negedge clk);
        do_reset();
        run_frame(900, 1'b1, 1'b0, "R2 R9 align restarts at 1 after mid-frame reset");
        run_frame(-900, 1'b1, 1'b0, "R2 align 0 after restart");
    endtask

    initial begin
        t_first_frames();
        t_full_scale();
        t_rounding();
        t_capture_hold();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule